// File: doc/BRIEF.md
# Multi-cycle instruction cycle sequencer

This block is the control unit and register set of a small accumulator machine. It walks every instruction through up to four subcycles: fetch, an optional indirect subcycle, execute, and an optional interrupt-entry subcycle. All memory traffic goes over one single-word port. The block raises a read or write strobe with an address and holds the request until the memory answers with a ready pulse. The program counter, memory address register, memory buffer register, instruction register, accumulator, stack pointer and interrupt-enable flag all live inside the block.

An instruction word carries three fields. Bit 15 is the indirect flag. Bits 14:12 hold the opcode. Bits 11:0 hold the operand address. When the indirect flag is set, the address field points at a memory word whose low 12 bits are the real operand address.

The interrupt request is looked at only when execute finishes. It is honoured only while the enable flag is set. Interrupt entry clears the enable flag, decrements the stack pointer, stores the return address at the new stack location, and then jumps to a fixed handler address.

Top module: `cycle_seq`

## Requirements
- R1: Fetch reads memory at the PC. On ready, the returned word becomes the instruction and the PC advances by one.
- R2: If bit 15 of the fetched word is 1, one extra read at the word's low 12 bits runs before execute. The low 12 bits of that read are then used as the operand address.
- R3: Execute acts on opcode bits 14:12 as follows. 0 loads the accumulator from the operand address. 1 stores the accumulator to the operand address. 2 adds the operand word to the accumulator. 3 loads the PC with the operand address.
- R4: A memory request keeps its strobe, address and write data unchanged until ready is seen.
- R5: Opcode 4 sets the interrupt-enable flag and opcode 5 clears it. An interrupt starts only if the request is high and the flag is already set when execute completes. The flag value written by that same instruction does not count. A request with the flag clear has no effect.
- R6: Interrupt entry clears the enable flag and decrements the stack pointer by one. It then writes the return address to the new stack location, which is SP_INIT-1 for the first entry.
- R7: After the save write completes, the PC holds HANDLER_ADDR and the next fetch reads from there.
- R8: While reset is held, the PC, accumulator and enable flag read zero and no write is requested.
- R9: Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address (MAR) |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid while ready is high |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_rdy | input | 1 | Memory completes the current request |
| irq | input | 1 | Interrupt request level |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | WORD_W | Accumulator |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
A wrong subcycle or a stale register shows up at the memory port on the very next completed transfer. Examples are a fetch from the wrong address, a missing or extra indirect read, a store of the wrong accumulator value, or a save write at the wrong stack slot. The bench therefore compares every completed transfer, in order, against the expected address and data. That catches an error within one instruction of where it arises. Interrupt gating faults show up as an early or missing save write. Faults in the accumulator and enable flag also surface through their output ports at the end of the run.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [1:0] {
    SC_FETCH = 2'd0,
    SC_IND   = 2'd1,
    SC_EXEC  = 2'd2,
    SC_INTR  = 2'd3
  } subcyc_e;

  localparam logic [OPC_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OPC_W-1:0] OP_STORE = 3'd1;
  localparam logic [OPC_W-1:0] OP_ADD   = 3'd2;
  localparam logic [OPC_W-1:0] OP_JUMP  = 3'd3;
  localparam logic [OPC_W-1:0] OP_SETIE = 3'd4;
  localparam logic [OPC_W-1:0] OP_CLRIE = 3'd5;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_rdy,
  input  logic             irq,
  input  logic             ie,
  input  logic             ind_bit,
  input  logic [OPC_W-1:0] op,
  output subcyc_e          state,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ev_fetch_done,
  output logic             ev_ind_done,
  output logic             ev_exec_done,
  output logic             ev_intr_enter,
  output logic             ev_save_done
);
  subcyc_e nxt;
  logic    op_reads, op_writes;

  assign op_reads  = (op == OP_LOAD) || (op == OP_ADD);
  assign op_writes = (op == OP_STORE);

  assign ev_fetch_done = (state == SC_FETCH) && mem_rdy;
  assign ev_ind_done   = (state == SC_IND) && mem_rdy;
  assign ev_exec_done  = (state == SC_EXEC) && (!(op_reads || op_writes) || mem_rdy);
  assign ev_intr_enter = ev_exec_done && irq && ie;
  assign ev_save_done  = (state == SC_INTR) && mem_rdy;

  assign mem_rd = (state == SC_FETCH) || (state == SC_IND) ||
                  ((state == SC_EXEC) && op_reads);
  assign mem_wr = (state == SC_INTR) || ((state == SC_EXEC) && op_writes);

  always_comb begin
    nxt = state;
    unique case (state)
      SC_FETCH: if (ev_fetch_done) nxt = ind_bit ? SC_IND : SC_EXEC;
      SC_IND:   if (ev_ind_done) nxt = SC_EXEC;
      SC_EXEC:  if (ev_exec_done) nxt = ev_intr_enter ? SC_INTR : SC_FETCH;
      SC_INTR:  if (ev_save_done) nxt = SC_FETCH;
      default:  nxt = SC_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SC_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
#(
  parameter int              WORD_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h200,
  parameter logic [ADDR_W-1:0] SP_INIT      = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  subcyc_e           state,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              ev_fetch_done,
  input  logic              ev_ind_done,
  input  logic              ev_exec_done,
  input  logic              ev_intr_enter,
  input  logic              ev_save_done,
  output logic [OPC_W-1:0]  op,
  output logic              ind_bit,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] acc,
  output logic              ie
);
  localparam int OPC_LSB = WORD_W - 1 - OPC_W;

  logic [WORD_W-1:0] ir, mbr;
  logic [ADDR_W-1:0] sp, pc_after;

  function automatic logic [ADDR_W-1:0] addr_field(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] acc_sum(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  assign op       = ir[OPC_LSB +: OPC_W];
  assign ind_bit  = mem_rdata[WORD_W-1];
  assign wdata    = (state == SC_INTR) ? mbr : acc;
  assign pc_after = (op == OP_JUMP) ? mar : pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      sp  <= SP_INIT;
      ie  <= 1'b0;
    end else begin
      if (ev_fetch_done) begin
        ir  <= mem_rdata;
        mbr <= mem_rdata;
        mar <= addr_field(mem_rdata);
        pc  <= pc_step(pc);
      end
      if (ev_ind_done) begin
        mbr <= mem_rdata;
        mar <= addr_field(mem_rdata);
      end
      if (ev_exec_done) begin
        if (op == OP_LOAD) acc <= mem_rdata;
        if (op == OP_ADD)  acc <= acc_sum(acc, mem_rdata);
        if (op == OP_JUMP) pc  <= mar;
        if (op == OP_SETIE) ie <= 1'b1;
        if (op == OP_CLRIE) ie <= 1'b0;
        if (ev_intr_enter) begin
          ie  <= 1'b0;
          sp  <= sp - ADDR_W'(1);
          mar <= sp - ADDR_W'(1);
          mbr <= WORD_W'(pc_after);
        end else begin
          mar <= pc_after;
        end
      end
      if (ev_save_done) begin
        pc  <= HANDLER_ADDR;
        mar <= HANDLER_ADDR;
      end
    end
  end
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import seq_pkg::*;
#(
  parameter int              WORD_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h200,
  parameter logic [ADDR_W-1:0] SP_INIT      = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_rdy,
  input  logic              irq,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              ie_o
);
  subcyc_e          state;
  logic [OPC_W-1:0] op;
  logic             ind_bit, ie;
  logic             ev_fetch_done, ev_ind_done, ev_exec_done;
  logic             ev_intr_enter, ev_save_done;

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .irq(irq), .ie(ie),
    .ind_bit(ind_bit), .op(op), .state(state), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ev_fetch_done(ev_fetch_done), .ev_ind_done(ev_ind_done),
    .ev_exec_done(ev_exec_done), .ev_intr_enter(ev_intr_enter),
    .ev_save_done(ev_save_done)
  );

  seq_regs #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .HANDLER_ADDR(HANDLER_ADDR), .SP_INIT(SP_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_rdata(mem_rdata),
    .ev_fetch_done(ev_fetch_done), .ev_ind_done(ev_ind_done),
    .ev_exec_done(ev_exec_done), .ev_intr_enter(ev_intr_enter),
    .ev_save_done(ev_save_done), .op(op), .ind_bit(ind_bit),
    .mar(mem_addr), .wdata(mem_wdata), .pc(pc_o), .acc(acc_o), .ie(ie)
  );

  assign ie_o = ie;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int              WORD_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_rdy,
  input logic              irq,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ie_o,
  input logic              ev_fetch_done,
  input logic              ev_intr_enter,
  input logic              ev_save_done
);
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> pc_o == $past(pc_o) + ADDR_W'(1));

  p_hold_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

  p_hold_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_intr_enter |-> (ie_o && irq));

  p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_intr_enter |=> (!ie_o && mem_wr && !mem_rd));

  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save_done |=> (pc_o == HANDLER_ADDR && mem_addr == HANDLER_ADDR && mem_rd));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind cycle_seq seq_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy), .irq(irq),
  .pc_o(pc_o), .ie_o(ie_o), .ev_fetch_done(ev_fetch_done),
  .ev_intr_enter(ev_intr_enter), .ev_save_done(ev_save_done)
);

// File: tb/sim_cycle_seq.sv
`timescale 1ns/1ps
module sim_cycle_seq;
  localparam int W = 16;
  localparam int A = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [A-1:0] mem_addr, pc_o;
  logic [W-1:0] mem_wdata, mem_rdata, acc_o;
  logic         mem_rd, mem_wr, mem_rdy, irq, ie_o;

  always #10 clk = ~clk;

  cycle_seq #(.WORD_W(W), .ADDR_W(A), .HANDLER_ADDR(12'h200), .SP_INIT(12'hF00)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy),
    .irq(irq), .pc_o(pc_o), .acc_o(acc_o), .ie_o(ie_o)
  );

  // memory model: latency of 0..3 cycles taken from the low address bits
  logic [W-1:0] mem [0:4095];
  int           wait_cnt;
  assign mem_rdy   = (mem_rd || mem_wr) && (wait_cnt >= int'(mem_addr[1:0]));
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) wait_cnt <= 0;
    else if ((mem_rd || mem_wr) && !mem_rdy) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (rst_n && mem_wr && mem_rdy) mem[mem_addr] <= mem_wdata;
  end

  typedef struct {
    bit           wr;
    logic [A-1:0] a;
    logic [W-1:0] d;
    string        tag;
  } xfer_t;

  xfer_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic push_exp(input bit wr, input logic [A-1:0] a, input logic [W-1:0] d,
                          input string tag);
    xfer_t x;
    x.wr = wr; x.a = a; x.d = d; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: every completed transfer is compared against the queue head
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr) && mem_rdy) begin
      logic [W-1:0] dat;
      dat = mem_wr ? mem_wdata : mem_rdata;
      chk(!(mem_rd && mem_wr), "R9 both strobes", {15'd0, mem_wr}, 16'h0);
      if (exp_q.size() > 0) begin
        xfer_t e;
        e = exp_q.pop_front();
        chk(mem_wr == e.wr && mem_addr == e.a, {e.tag, " addr/kind"},
            {3'(0), mem_wr, mem_addr}, {3'(0), e.wr, e.a});
        chk(dat == e.d, {e.tag, " data"}, dat, e.d);
      end else begin
        // idle loop: only the self-jump fetch at 0x012 may appear (R5 masked irq)
        chk(!mem_wr && mem_addr == 12'h012, "R5 masked irq caused traffic",
            {4'd0, mem_addr}, 16'h0012);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // main program
    mem[12'h000] = 16'h0100; // LOAD 0x100
    mem[12'h001] = 16'hA101; // ADD indirect via 0x101
    mem[12'h002] = 16'h1103; // STORE 0x103
    mem[12'h003] = 16'h4000; // SETIE
    mem[12'h004] = 16'h3010; // JUMP 0x010
    mem[12'h010] = 16'h8105; // LOAD indirect via 0x105
    mem[12'h011] = 16'h5000; // CLRIE
    mem[12'h012] = 16'h3012; // JUMP self
    mem[12'h100] = 16'h0005;
    mem[12'h101] = 16'h0102;
    mem[12'h102] = 16'h0007;
    mem[12'h105] = 16'h0106;
    mem[12'h106] = 16'h0033;
    // handler
    mem[12'h200] = 16'h1104; // STORE 0x104
    mem[12'h201] = 16'h4000; // SETIE
    mem[12'h202] = 16'h3010; // JUMP 0x010

    rst_n = 1'b0;
    irq   = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc_o == '0, "R8 reset pc", {4'd0, pc_o}, 16'h0);
    chk(acc_o == '0, "R8 reset acc", acc_o, 16'h0);
    chk(ie_o == 1'b0, "R8 reset ie", {15'd0, ie_o}, 16'h0);
    chk(mem_wr == 1'b0, "R8 reset no write", {15'd0, mem_wr}, 16'h0);

    push_exp(0, 12'h000, 16'h0100, "R1 fetch 0");
    push_exp(0, 12'h100, 16'h0005, "R3 load operand");
    push_exp(0, 12'h001, 16'hA101, "R1 fetch 1");
    push_exp(0, 12'h101, 16'h0102, "R2 indirect read");
    push_exp(0, 12'h102, 16'h0007, "R3 add operand");
    push_exp(0, 12'h002, 16'h1103, "R1 fetch 2");
    push_exp(1, 12'h103, 16'h000C, "R3 store sum");
    push_exp(0, 12'h003, 16'h4000, "R5 fetch setie");
    push_exp(0, 12'h004, 16'h3010, "R5 no irq before ie");
    push_exp(1, 12'hEFF, 16'h0010, "R6 save return addr");
    push_exp(0, 12'h200, 16'h1104, "R7 handler fetch");
    push_exp(1, 12'h104, 16'h000C, "R3 store in handler");
    push_exp(0, 12'h201, 16'h4000, "R1 fetch 201");
    push_exp(0, 12'h202, 16'h3010, "R1 fetch 202");
    push_exp(0, 12'h010, 16'h8105, "R3 jump target fetch");
    push_exp(0, 12'h105, 16'h0106, "R2 indirect read 2");
    push_exp(0, 12'h106, 16'h0033, "R2 operand via pointer");
    push_exp(0, 12'h011, 16'h5000, "R1 fetch clrie");
    push_exp(0, 12'h012, 16'h3012, "R3 self jump");

    irq = 1'b1;          // pending from the start: masked until IE set
    @(negedge clk);
    rst_n = 1'b1;

    @(negedge ie_o);     // interrupt entry cleared IE
    @(negedge clk);
    chk(ie_o == 1'b0, "R6 ie cleared on entry", {15'd0, ie_o}, 16'h0);
    irq = 1'b0;

    wait (exp_q.size() == 0);
    irq = 1'b1;          // IE now clear: must be ignored
    repeat (40) @(negedge clk);
    chk(ie_o == 1'b0, "R5 ie stays clear", {15'd0, ie_o}, 16'h0);
    chk(acc_o == 16'h0033, "R3 final acc", acc_o, 16'h0033);
    chk(pc_o == 12'h012 || pc_o == 12'h013, "R5 pc in loop", {4'd0, pc_o}, 16'h0012);
    chk(mem[12'h103] == 16'h000C, "R3 stored word", mem[12'h103], 16'h000C);
    chk(mem[12'hEFF] == 16'h0010, "R6 saved pc in memory", mem[12'hEFF], 16'h0010);
    chk(mem[12'hEFE] == 16'h0000, "R5 no second save", mem[12'hEFE], 16'h0000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, queue left=%0d expected=0", exp_q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule